// File: doc/BRIEF.md
# UTMI 8/16-bit bus adapter

This block joins a byte-wide serial engine to the parallel data pins of a UTMI-style link interface. The engine side uses two byte streams, one for transmit and one for receive. The pin side is a 16-bit data bus with one of three layouts:

- a full 16-bit word per interface clock, with a high-byte qualifier;
- an 8-bit bidirectional lane on the low pins;
- an 8-bit unidirectional layout, in which transmit bytes enter on the low pins and receive bytes leave on the high pins.

The layout is chosen by two strap inputs. The straps are sampled on every clock while reset is held, and are frozen once reset is released.

On transmit, a word offered with the transmit-valid input is taken into a holding stage. In 16-bit mode a word carries either two bytes or one byte, depending on the high-byte qualifier, so odd-length packets are possible. The bytes are then handed to the engine low byte first.

On receive, engine bytes are presented on the pins one cycle after they arrive. In 16-bit mode they are first paired into words. A packet that ends on an odd byte leaves that byte alone in the low lane, with the qualifier low.

Pin direction follows transmit-valid. While transmit-valid is high, the block releases the lanes and the qualifier that it would otherwise drive.

The design has three control pieces:

- The strap register holds one of three layouts: BUS_BIDIR8, BUS_UNI8 or BUS_WIDE. It loads only while reset is high.
- The transmit machine has three states:
  - TX_EMPTY goes to TX_LAST when a one-byte word is accepted, and to TX_PAIR when a two-byte word is accepted.
  - TX_PAIR goes to TX_LAST when the engine takes the low byte.
  - TX_LAST goes to TX_EMPTY when the engine takes the byte. If a new word is accepted in that same cycle, it goes to TX_LAST or TX_PAIR instead.
- The receive machine has two states:
  - RX_IDLE goes to RX_HALF when a non-final byte arrives in 16-bit mode.
  - RX_HALF returns to RX_IDLE on the next byte.

Top module: `utmi_bus_adapter`

## Requirements
- R1: The layout is captured while `rst` is high and is frozen afterwards. `strap_wide`=1 selects 16-bit mode whatever `strap_uni` is. `strap_wide`=0 with `strap_uni`=1 selects unidirectional 8-bit mode. Both low selects bidirectional 8-bit mode.
- R2: In both 8-bit modes, a byte on `bus_din[7:0]` is accepted at an edge where `bus_tx_valid` and `bus_tx_ready` are both high. From the next cycle it appears on `ser_tx_data` with `ser_tx_valid` high, and it stays there until an edge with `ser_tx_ready` high.
- R3: In 16-bit mode, an accepted word with `bus_hiq_in`=1 yields `bus_din[7:0]` and then `bus_din[15:8]` on the engine side. `bus_tx_ready` stays low while the second byte is still pending.
- R4: In 16-bit mode, an accepted word with `bus_hiq_in`=0 yields only `bus_din[7:0]`. The upper pins are ignored.
- R5: In bidirectional 8-bit mode, each engine receive byte appears on `bus_dout[7:0]` with `bus_rx_valid` high in the cycle after it arrives.
- R6: In unidirectional 8-bit mode, each engine receive byte appears on `bus_dout[15:8]` with `bus_rx_valid` high in the cycle after it arrives.
- R7: In 16-bit mode, receive bytes are paired: the first byte goes to the low lane and the second to the high lane. The word appears with `bus_rx_valid`=1 and `bus_hiq_out`=1 in the cycle after the second byte arrives.
- R8: In 16-bit mode, a byte marked with `ser_rx_last` that arrives with no unpaired byte waiting appears alone on `bus_dout[7:0]`, with `bus_rx_valid`=1 and `bus_hiq_out`=0.
- R9: `bus_oe_lo` is high only in the two bidirectional layouts and only while `bus_tx_valid` is low. `bus_oe_hi` is always high in unidirectional mode, high in 16-bit mode while `bus_tx_valid` is low, and never high in bidirectional 8-bit mode. `bus_hiq_oe` is high only in 16-bit mode with `bus_tx_valid` low.
- R10: When only one byte is waiting, `bus_tx_ready` is high in any cycle where `ser_tx_ready` is high. With the engine always ready, 8-bit transmit therefore runs at one byte per cycle.
- R11: In cycles where no word completes, `bus_rx_valid` and `bus_hiq_out` are 0.
- R12: After reset, `bus_tx_ready`=1, `ser_tx_valid`=0, `bus_rx_valid`=0 and `bus_hiq_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high; the straps are sampled while it is high |
| strap_wide | input | 1 | Layout strap: 1 selects the 16-bit word bus |
| strap_uni | input | 1 | Layout strap: 1 selects split directions when the bus is 8-bit |
| bus_tx_valid | input | 1 | Link side is offering transmit data; also sets the pin direction |
| bus_tx_ready | output | 1 | The block takes the offered word at this edge |
| bus_din | input | 16 | Values sampled from the data pins |
| bus_dout | output | 16 | Receive values driven to the data pins |
| bus_oe_lo | output | 1 | Drive enable for pins 7..0 |
| bus_oe_hi | output | 1 | Drive enable for pins 15..8 |
| bus_hiq_in | input | 1 | High-byte qualifier sampled during transmit |
| bus_hiq_out | output | 1 | High-byte qualifier driven during receive |
| bus_hiq_oe | output | 1 | Drive enable for the qualifier pin |
| bus_rx_valid | output | 1 | A receive byte or word is on the pins |
| ser_tx_data | output | 8 | Transmit byte to the serial engine |
| ser_tx_valid | output | 1 | `ser_tx_data` holds a byte |
| ser_tx_ready | input | 1 | The engine takes the byte at this edge |
| ser_rx_data | input | 8 | Receive byte from the serial engine |
| ser_rx_valid | input | 1 | `ser_rx_data` holds a byte this cycle |
| ser_rx_last | input | 1 | This byte ends the packet |

## Verification
The bench attacks these cases:

- **Engine ready while a word is accepted.** A byte is consumed from a single-byte hold in the same cycle that a new word is accepted. A design that allowed this back-to-back acceptance from TX_PAIR would lose the upper byte. One that forbade it from TX_LAST would fall short of one byte per cycle.
- **Odd packet ends.** A final byte arrives both on an even boundary and on an odd one. A pairing machine that ignored the end mark would hold a lone byte and merge it with the first byte of the next packet. One that honoured it in RX_HALF would split a valid pair.
- **Straps changed after reset.** Flipping the straps after release would expose a design that tracks them live: lanes, enables and pairing would shift mid-stream.
- **Turnaround and layout priority.** Transmit-valid toggles while words are still being received. This catches enables that ignore turnaround, or that ignore the priority of the wide strap over the unidirectional one.

// File: rtl/uba_pkg.sv
package uba_pkg;

    typedef enum logic [1:0] {
        BUS_BIDIR8 = 2'd0,
        BUS_UNI8   = 2'd1,
        BUS_WIDE   = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        TX_EMPTY = 2'd0,
        TX_LAST  = 2'd1,
        TX_PAIR  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HALF = 1'b1
    } rx_state_e;

endpackage

// File: rtl/uba_strap.sv
module uba_strap
    import uba_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strap_wide,
    input  logic      strap_uni,
    output bus_mode_e mode
);

    bus_mode_e sel_mode;

    always_comb begin
        if (strap_wide)
            sel_mode = BUS_WIDE;
        else if (strap_uni)
            sel_mode = BUS_UNI8;
        else
            sel_mode = BUS_BIDIR8;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= sel_mode;
    end

endmodule

// File: rtl/uba_tx.sv
module uba_tx
    import uba_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              word_valid,
    input  logic [BYTE_W-1:0] word_lo,
    input  logic [BYTE_W-1:0] word_hi,
    input  logic              word_hiq,
    output logic              word_ready,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    input  logic              byte_ready
);

    tx_state_e         state;
    tx_state_e         state_nxt;
    logic              accept;
    logic              two_bytes;
    logic [BYTE_W-1:0] cur_q;
    logic [BYTE_W-1:0] hi_q;

    assign two_bytes = wide && word_hiq;
    assign accept    = word_valid && word_ready;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= TX_EMPTY;
        else
            state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_EMPTY: begin
                if (accept)
                    state_nxt = two_bytes ? TX_PAIR : TX_LAST;
            end
            TX_LAST: begin
                if (byte_ready) begin
                    if (accept)
                        state_nxt = two_bytes ? TX_PAIR : TX_LAST;
                    else
                        state_nxt = TX_EMPTY;
                end
            end
            TX_PAIR: begin
                if (byte_ready)
                    state_nxt = TX_LAST;
            end
            default: state_nxt = TX_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        word_ready = (state == TX_EMPTY) || ((state == TX_LAST) && byte_ready);
        byte_valid = (state != TX_EMPTY);
        byte_data  = cur_q;
    end

    // byte holding stage
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            hi_q  <= '0;
        end else if (accept) begin
            cur_q <= word_lo;
            hi_q  <= word_hi;
        end else if ((state == TX_PAIR) && byte_ready) begin
            cur_q <= hi_q;
        end
    end

endmodule

// File: rtl/uba_rx.sv
module uba_rx
    import uba_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    output logic [BYTE_W-1:0] out_lo,
    output logic [BYTE_W-1:0] out_hi,
    output logic              out_valid,
    output logic              out_hiq
);

    rx_state_e         state;
    rx_state_e         state_nxt;
    logic [BYTE_W-1:0] held_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= RX_IDLE;
        else
            state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE: begin
                if (byte_valid && wide && !byte_last)
                    state_nxt = RX_HALF;
            end
            RX_HALF: begin
                if (byte_valid)
                    state_nxt = RX_IDLE;
            end
            default: state_nxt = RX_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_lo    <= '0;
            out_hi    <= '0;
            out_valid <= 1'b0;
            out_hiq   <= 1'b0;
            held_q    <= '0;
        end else begin
            out_valid <= 1'b0;
            out_hiq   <= 1'b0;
            if (byte_valid) begin
                if (!wide) begin
                    out_lo    <= byte_data;
                    out_hi    <= byte_data;
                    out_valid <= 1'b1;
                end else if (state == RX_HALF) begin
                    out_lo    <= held_q;
                    out_hi    <= byte_data;
                    out_valid <= 1'b1;
                    out_hiq   <= 1'b1;
                end else if (byte_last) begin
                    out_lo    <= byte_data;
                    out_valid <= 1'b1;
                end else begin
                    held_q    <= byte_data;
                end
            end
        end
    end

endmodule

// File: rtl/utmi_bus_adapter.sv
module utmi_bus_adapter
    import uba_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int BUS_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_wide,
    input  logic              strap_uni,
    input  logic              bus_tx_valid,
    output logic              bus_tx_ready,
    input  logic [BUS_W-1:0]  bus_din,
    output logic [BUS_W-1:0]  bus_dout,
    output logic              bus_oe_lo,
    output logic              bus_oe_hi,
    input  logic              bus_hiq_in,
    output logic              bus_hiq_out,
    output logic              bus_hiq_oe,
    output logic              bus_rx_valid,
    output logic [BYTE_W-1:0] ser_tx_data,
    output logic              ser_tx_valid,
    input  logic              ser_tx_ready,
    input  logic [BYTE_W-1:0] ser_rx_data,
    input  logic              ser_rx_valid,
    input  logic              ser_rx_last
);

    bus_mode_e         mode;
    logic              wide;
    logic [BYTE_W-1:0] rx_lo;
    logic [BYTE_W-1:0] rx_hi;
    logic              rx_hiq;

    uba_strap u_strap (
        .clk        (clk),
        .rst        (rst),
        .strap_wide (strap_wide),
        .strap_uni  (strap_uni),
        .mode       (mode)
    );

    assign wide = (mode == BUS_WIDE);

    uba_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .wide       (wide),
        .word_valid (bus_tx_valid),
        .word_lo    (bus_din[BYTE_W-1:0]),
        .word_hi    (bus_din[BUS_W-1:BYTE_W]),
        .word_hiq   (bus_hiq_in),
        .word_ready (bus_tx_ready),
        .byte_data  (ser_tx_data),
        .byte_valid (ser_tx_valid),
        .byte_ready (ser_tx_ready)
    );

    uba_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .wide       (wide),
        .byte_valid (ser_rx_valid),
        .byte_data  (ser_rx_data),
        .byte_last  (ser_rx_last),
        .out_lo     (rx_lo),
        .out_hi     (rx_hi),
        .out_valid  (bus_rx_valid),
        .out_hiq    (rx_hiq)
    );

    // lane placement and turnaround
    always_comb begin
        unique case (mode)
            BUS_WIDE: begin
                bus_dout  = {rx_hi, rx_lo};
                bus_oe_lo = !bus_tx_valid;
                bus_oe_hi = !bus_tx_valid;
            end
            BUS_UNI8: begin
                bus_dout  = {rx_hi, {BYTE_W{1'b0}}};
                bus_oe_lo = 1'b0;
                bus_oe_hi = 1'b1;
            end
            default: begin
                bus_dout  = {{BYTE_W{1'b0}}, rx_lo};
                bus_oe_lo = !bus_tx_valid;
                bus_oe_hi = 1'b0;
            end
        endcase
        bus_hiq_oe  = wide && !bus_tx_valid;
        bus_hiq_out = rx_hiq;
    end

endmodule

// File: rtl/uba_chk.sv
module uba_chk
    import uba_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input bus_mode_e  mode,
    input logic       bus_tx_valid,
    input logic       bus_tx_ready,
    input logic [7:0] bus_din_lo,
    input logic       bus_hiq_in,
    input logic       bus_oe_lo,
    input logic       bus_oe_hi,
    input logic       bus_hiq_out,
    input logic       bus_hiq_oe,
    input logic       bus_rx_valid,
    input logic [7:0] ser_tx_data,
    input logic       ser_tx_valid,
    input logic       ser_tx_ready,
    input logic       ser_rx_valid
);

    // R1
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode));

    // R2
    byte_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != BUS_WIDE && bus_tx_valid && bus_tx_ready)
        |=> (ser_tx_valid && ser_tx_data == $past(bus_din_lo)));

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_tx_valid && !ser_tx_ready) |=> (ser_tx_valid && $stable(ser_tx_data)));

    // R3
    pair_block_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_WIDE && bus_tx_valid && bus_tx_ready && bus_hiq_in)
        |=> (!bus_tx_ready && ser_tx_data == $past(bus_din_lo)));

    // R5
    rx_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != BUS_WIDE && ser_rx_valid) |=> bus_rx_valid);

    // R9
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        bus_tx_valid |-> (!bus_oe_lo && !bus_hiq_oe));

    // R9
    narrow_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_BIDIR8) |-> !bus_oe_hi);

    // R11
    hiq_valid_chk: assert property (@(posedge clk) disable iff (rst)
        bus_hiq_out |-> bus_rx_valid);

endmodule

bind utmi_bus_adapter uba_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .bus_tx_valid (bus_tx_valid),
    .bus_tx_ready (bus_tx_ready),
    .bus_din_lo   (bus_din[7:0]),
    .bus_hiq_in   (bus_hiq_in),
    .bus_oe_lo    (bus_oe_lo),
    .bus_oe_hi    (bus_oe_hi),
    .bus_hiq_out  (bus_hiq_out),
    .bus_hiq_oe   (bus_hiq_oe),
    .bus_rx_valid (bus_rx_valid),
    .ser_tx_data  (ser_tx_data),
    .ser_tx_valid (ser_tx_valid),
    .ser_tx_ready (ser_tx_ready),
    .ser_rx_valid (ser_rx_valid)
);

// File: tb/utmi_bus_adapter_tb.sv
module utmi_bus_adapter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_wide = 1'b1;
    logic        strap_uni = 1'b0;
    logic        bus_tx_valid = 1'b0;
    logic        bus_tx_ready;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;
    logic        bus_oe_lo, bus_oe_hi;
    logic        bus_hiq_in = 1'b0;
    logic        bus_hiq_out, bus_hiq_oe;
    logic        bus_rx_valid;
    logic [7:0]  ser_tx_data;
    logic        ser_tx_valid;
    logic        ser_tx_ready = 1'b0;
    logic [7:0]  ser_rx_data = '0;
    logic        ser_rx_valid = 1'b0;
    logic        ser_rx_last = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    utmi_bus_adapter u_dut (
        .clk          (clk),
        .rst          (rst),
        .strap_wide   (strap_wide),
        .strap_uni    (strap_uni),
        .bus_tx_valid (bus_tx_valid),
        .bus_tx_ready (bus_tx_ready),
        .bus_din      (bus_din),
        .bus_dout     (bus_dout),
        .bus_oe_lo    (bus_oe_lo),
        .bus_oe_hi    (bus_oe_hi),
        .bus_hiq_in   (bus_hiq_in),
        .bus_hiq_out  (bus_hiq_out),
        .bus_hiq_oe   (bus_hiq_oe),
        .bus_rx_valid (bus_rx_valid),
        .ser_tx_data  (ser_tx_data),
        .ser_tx_valid (ser_tx_valid),
        .ser_tx_ready (ser_tx_ready),
        .ser_rx_data  (ser_rx_data),
        .ser_rx_valid (ser_rx_valid),
        .ser_rx_last  (ser_rx_last)
    );

    // behavioural reference: 0 = 8-bit bidir, 1 = 8-bit uni, 2 = 16-bit
    int         m_mode = 2;
    logic [7:0] txq[$];
    bit         have_low = 1'b0;
    logic [7:0] low_byte = '0;
    bit         e_rv = 1'b0;
    bit         e_hiq = 1'b0;
    logic [7:0] e_lo = '0;
    logic [7:0] e_hi = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = strap_wide ? 2 : (strap_uni ? 1 : 0);
            txq.delete();
            have_low = 1'b0;
            e_rv = 1'b0;
            e_hiq = 1'b0;
        end else begin
            bit rdy;
            rdy = (txq.size() == 0) || (txq.size() == 1 && ser_tx_ready);
            if (txq.size() > 0 && ser_tx_ready) void'(txq.pop_front());
            if (bus_tx_valid && rdy) begin
                txq.push_back(bus_din[7:0]);
                if (m_mode == 2 && bus_hiq_in) txq.push_back(bus_din[15:8]);
            end
            e_rv = 1'b0;
            e_hiq = 1'b0;
            if (ser_rx_valid) begin
                if (m_mode != 2) begin
                    e_rv = 1'b1;
                    e_lo = ser_rx_data;
                    e_hi = ser_rx_data;
                end else if (have_low) begin
                    e_rv = 1'b1;
                    e_hiq = 1'b1;
                    e_lo = low_byte;
                    e_hi = ser_rx_data;
                    have_low = 1'b0;
                end else if (ser_rx_last) begin
                    e_rv = 1'b1;
                    e_lo = ser_rx_data;
                end else begin
                    have_low = 1'b1;
                    low_byte = ser_rx_data;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit exp_rdy;
        bit e_oe_lo, e_oe_hi, e_hoe;
        exp_rdy = (txq.size() == 0) || (txq.size() == 1 && ser_tx_ready);
        chk(bus_tx_ready == exp_rdy, "R3 R10 tx_ready", bus_tx_ready, exp_rdy);
        chk(ser_tx_valid == (txq.size() > 0), "R2 ser_tx_valid", ser_tx_valid, txq.size() > 0);
        if (txq.size() > 0)
            chk(ser_tx_data == txq[0], "R2 R3 R4 ser_tx_data", ser_tx_data, txq[0]);
        chk(bus_rx_valid == e_rv, "R11 rx_valid", bus_rx_valid, e_rv);
        chk(bus_hiq_out == e_hiq, "R7 R8 hiq_out", bus_hiq_out, e_hiq);
        if (e_rv) begin
            if (m_mode == 0)
                chk(bus_dout[7:0] == e_lo, "R5 low lane", bus_dout[7:0], e_lo);
            else if (m_mode == 1)
                chk(bus_dout[15:8] == e_hi, "R6 high lane", bus_dout[15:8], e_hi);
            else if (e_hiq)
                chk(bus_dout == {e_hi, e_lo}, "R7 word", bus_dout, {e_hi, e_lo});
            else
                chk(bus_dout[7:0] == e_lo, "R8 odd byte", bus_dout[7:0], e_lo);
        end
        e_oe_lo = (m_mode != 1) && !bus_tx_valid;
        e_oe_hi = (m_mode == 1) || (m_mode == 2 && !bus_tx_valid);
        e_hoe   = (m_mode == 2) && !bus_tx_valid;
        chk(bus_oe_lo == e_oe_lo, "R1 R9 oe_lo", bus_oe_lo, e_oe_lo);
        chk(bus_oe_hi == e_oe_hi, "R1 R9 oe_hi", bus_oe_hi, e_oe_hi);
        chk(bus_hiq_oe == e_hoe, "R9 hiq_oe", bus_hiq_oe, e_hoe);
    endtask

    task automatic do_reset(input bit w, input bit u);
        strap_wide = w;
        strap_uni = u;
        bus_tx_valid = 1'b0;
        ser_rx_valid = 1'b0;
        ser_tx_ready = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(bus_tx_ready == 1'b1, "R12 tx_ready", bus_tx_ready, 1);
        chk(ser_tx_valid == 1'b0, "R12 ser_tx_valid", ser_tx_valid, 0);
        chk(bus_rx_valid == 1'b0, "R12 rx_valid", bus_rx_valid, 0);
        chk(bus_hiq_out == 1'b0, "R12 hiq_out", bus_hiq_out, 0);
    endtask

    task automatic run(input int cycles, input int rdy_pct, input bit flip_straps);
        for (int i = 0; i < cycles; i++) begin
            compare_all();
            bus_tx_valid = ($urandom % 4) != 0;
            bus_din = 16'($urandom);
            bus_hiq_in = ($urandom % 3) != 0;
            ser_tx_ready = ($urandom % 100) < rdy_pct;
            ser_rx_valid = ($urandom % 2) != 0;
            ser_rx_data = 8'($urandom);
            ser_rx_last = ($urandom % 5) == 0;
            if (flip_straps) begin
                strap_wide = $urandom % 2;
                strap_uni = $urandom % 2;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1, 1'b0);            // 16-bit: R3 R4 R7 R8
        run(600, 60, 1'b0);
        run(200, 100, 1'b0);
        do_reset(1'b0, 1'b0);            // 8-bit bidir: R2 R5 R10
        run(400, 60, 1'b0);
        run(200, 100, 1'b0);
        do_reset(1'b0, 1'b1);            // 8-bit uni: R6
        run(400, 70, 1'b0);
        do_reset(1'b1, 1'b1);            // R1 priority, then straps toggled
        run(400, 60, 1'b1);
        do_reset(1'b0, 1'b1);            // R1 frozen while straps move
        run(300, 80, 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule